// File: doc/BRIEF.md
# Shading-Based Row Elevation Unit

This block turns one grayscale frame into a relative height profile along each image row, using only pixel brightness and a known horizontal light angle. The surface is taken as a diffuse reflector lit by parallel rays. The brightest object pixel therefore faces the light, and the darkest object pixel lies edge-on to it. Every pixel in between gets a slope angle by linear interpolation on its brightness. The tangent of that slope gives a height step. The step is signed by comparing the pixel with its left neighbour, and a running sum along the row turns the steps into an elevation.

The same frame is streamed into the block twice, in raster order with a fixed frame size. In the first pass, the block finds each row's object span: the first and last pixel brighter than a background threshold. It also finds the darkest and brightest pixel inside those spans over the whole frame. Between the passes, a short sequential division computes the interpolation gain, and the input is stalled while it runs. In the second pass, the block produces one signed elevation per pixel, with a marker on the last column of each row.

Control is a four-state machine. `ST_SCAN` accepts the first pass and moves to `ST_LOAD` when the last pixel of the frame is taken. `ST_LOAD` latches the light angle. It goes straight to `ST_MAP` when the brightness range is empty or zero, and otherwise starts the divider and moves to `ST_DIV`. `ST_DIV` moves to `ST_MAP` when the quotient is ready. `ST_MAP` accepts the second pass and returns to `ST_SCAN` after the last pixel of the frame.

Top module: `shade_row_elev`

## Requirements
- R1: For each row, the span runs from the first to the last column whose value is strictly greater than `thresh` during the first pass. Any second-pass pixel outside the span, and every pixel of a row with no such column, outputs elevation 0.
- R2: The frame minimum and maximum are taken over all span pixels of the first pass, including span pixels at or below the threshold. Pixels outside the spans are not included.
- R3: Angles are expressed in units of 90/256 degree. With a = min(alpha, 256), N = 256 - 2a, D = max - min, K = floor(|N|·65536/D) and q = floor((max - I)·K/65536), the slope index is a + q when N ≥ 0 and a - q otherwise, capped at 255.
- R4: When the frame has no span pixel, or when max equals min, every span pixel uses slope index a, capped at 255.
- R5: The height step magnitude for slope index k is round(tan(k·π/512)·256), as unsigned Q8.8.
- R6: The step is positive when the pixel is greater than or equal to its left neighbour, and negative otherwise. The first span pixel of a row always takes a positive step.
- R7: The output elevation of a span pixel is the sum of the signed steps of the earlier span pixels in the same row. The sum therefore restarts at every row, and the first span pixel outputs 0.
- R8: The running sum saturates at 2^19 - 1 and -2^19 in a 20-bit two's-complement output.
- R9: Each accepted second-pass pixel yields exactly one `out_valid` beat, in input order, three cycles after acceptance. `out_row_end` is high on the beat for column COLS-1. First-pass pixels yield no beats.
- R10: `in_ready` is high after reset and throughout both passes. It is low from the cycle after the last first-pass pixel until the gain is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel can be taken this cycle |
| in_pix | input | 8 | Brightness of the pixel, raster order |
| thresh | input | 8 | Background level, held for the frame |
| alpha | input | 9 | Horizontal light angle in 90/256 degree units (above 256 is clipped) |
| out_valid | output | 1 | Elevation beat present |
| out_elev | output | 20 | Signed elevation in Q8.8 units |
| out_row_end | output | 1 | Beat belongs to the last column of a row |

## Verification
Random frames with random spans, including dips below the threshold inside a span, are run with light angles below and above 45 degrees. Together they separate a wrong regression direction from a wrong gain or a wrong span. One frame places the global minimum on an in-span pixel that sits under the threshold, which shows whether the minimum search follows the span or the threshold. Flat frames with a single brightness level and an empty frame exercise the zero-range path and the all-zero output. A row of equal dark pixels under grazing light drives the running sum into saturation.

// File: rtl/shade_elev_pkg.sv
package shade_elev_pkg;

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_LOAD = 2'd1,
        ST_DIV  = 2'd2,
        ST_MAP  = 2'd3
    } elev_state_e;

    localparam real PI_C = 3.141592653589793;

    // Q8.8 tangent of entry idx of a table that splits a right angle into n steps
    function automatic logic [15:0] tan_q88(input int idx, input int n);
        real ang;
        real val;
        ang = real'(idx) * PI_C / (2.0 * real'(n));
        val = $tan(ang) * 256.0 + 0.5;
        if (val > 65535.0) begin
            return 16'hFFFF;
        end
        return 16'($rtoi(val));
    endfunction

endpackage

// File: rtl/shade_tan_rom.sv
module shade_tan_rom
    import shade_elev_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      tan_q
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [15:0] table_w [ENTRIES];

    generate
        for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
            localparam logic [15:0] ENTRY_V = tan_q88(k, ENTRIES);
            assign table_w[k] = ENTRY_V;
        end
    endgenerate

    assign tan_q = table_w[idx];

endmodule

// File: rtl/shade_slope_div.sv
module shade_slope_div #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   shifted;
    logic             take;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        take    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                num_q  <= num;
                den_q  <= den;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= take ? (shifted - {1'b0, den_q}) : shifted;
                quo_q <= {quo_q[NUM_W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = quo_q;

    // quotient must be the floor of num/den once the loop ends
    logic [NUM_W+DEN_W:0] chk_lo;
    logic [NUM_W+DEN_W:0] chk_hi;
    assign chk_lo = (NUM_W+DEN_W+1)'(quo_q) * (NUM_W+DEN_W+1)'(den_q);
    assign chk_hi = chk_lo + (NUM_W+DEN_W+1)'(den_q);

    p_quot_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (chk_lo <= (NUM_W+DEN_W+1)'(num_q)) && (chk_hi > (NUM_W+DEN_W+1)'(num_q)));

endmodule

// File: rtl/shade_span_scan.sv
module shade_span_scan #(
    parameter int COLS  = 64,
    parameter int ROWS  = 16,
    parameter int PIX_W = 8,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] thresh,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_found,
    output logic [COL_W-1:0] rd_first,
    output logic [COL_W-1:0] rd_last,
    output logic [PIX_W-1:0] fmin,
    output logic [PIX_W-1:0] fmax,
    output logic             obj_seen
);
    localparam logic [PIX_W-1:0] PMAX = '1;

    logic             found_q, found_c, found_n;
    logic [COL_W-1:0] first_q, first_n;
    logic [COL_W-1:0] last_q, last_n;
    logic [PIX_W-1:0] cmin_q, cmin_c, cmin_n;
    logic [PIX_W-1:0] tmin_q, tmin_c, tmin_n;
    logic [PIX_W-1:0] rmax_q, rmax_c, rmax_n;
    logic [PIX_W-1:0] fmin_q, fmin_c, fmin_n;
    logic [PIX_W-1:0] fmax_q, fmax_c, fmax_n;
    logic             obj_q, obj_c, obj_n;
    logic             above, row_end, frame_begin;
    logic [PIX_W-1:0] low3;

    logic             bnd_found [ROWS];
    logic [COL_W-1:0] bnd_first [ROWS];
    logic [COL_W-1:0] bnd_last  [ROWS];

    always_comb begin
        above       = pix > thresh;
        row_end     = col == COL_W'(COLS - 1);
        frame_begin = (row == '0) && (col == '0);

        found_c = (col == '0) ? 1'b0 : found_q;
        cmin_c  = (col == '0) ? PMAX : cmin_q;
        tmin_c  = (col == '0) ? PMAX : tmin_q;
        rmax_c  = (col == '0) ? '0   : rmax_q;

        found_n = found_c | above;
        first_n = (above && !found_c) ? col : first_q;
        last_n  = above ? col : last_q;

        low3 = (tmin_c < cmin_c) ? tmin_c : cmin_c;
        if (pix < low3) begin
            low3 = pix;
        end

        if (above) begin
            cmin_n = low3;
            tmin_n = PMAX;
            rmax_n = (pix > rmax_c) ? pix : rmax_c;
        end else begin
            cmin_n = cmin_c;
            tmin_n = (found_c && pix < tmin_c) ? pix : tmin_c;
            rmax_n = rmax_c;
        end

        fmin_c = frame_begin ? PMAX : fmin_q;
        fmax_c = frame_begin ? '0   : fmax_q;
        obj_c  = frame_begin ? 1'b0 : obj_q;

        fmin_n = fmin_c;
        fmax_n = fmax_c;
        obj_n  = obj_c;
        if (row_end && found_n) begin
            fmin_n = (cmin_n < fmin_c) ? cmin_n : fmin_c;
            fmax_n = (rmax_n > fmax_c) ? rmax_n : fmax_c;
            obj_n  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            found_q <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
            cmin_q  <= PMAX;
            tmin_q  <= PMAX;
            rmax_q  <= '0;
            fmin_q  <= PMAX;
            fmax_q  <= '0;
            obj_q   <= 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                bnd_found[r] <= 1'b0;
                bnd_first[r] <= '0;
                bnd_last[r]  <= '0;
            end
        end else if (acc) begin
            found_q <= found_n;
            first_q <= first_n;
            last_q  <= last_n;
            cmin_q  <= cmin_n;
            tmin_q  <= tmin_n;
            rmax_q  <= rmax_n;
            fmin_q  <= fmin_n;
            fmax_q  <= fmax_n;
            obj_q   <= obj_n;
            if (row_end) begin
                bnd_found[row] <= found_n;
                bnd_first[row] <= first_n;
                bnd_last[row]  <= last_n;
            end
        end
    end

    assign rd_found = bnd_found[rd_row];
    assign rd_first = bnd_first[rd_row];
    assign rd_last  = bnd_last[rd_row];
    assign fmin     = fmin_q;
    assign fmax     = fmax_q;
    assign obj_seen = obj_q;

    p_span_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_found |-> (rd_first <= rd_last));

    p_minmax_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        obj_q |-> (fmin_q <= fmax_q));

endmodule

// File: rtl/shade_row_elev.sv
module shade_row_elev
    import shade_elev_pkg::*;
#(
    parameter int COLS   = 64,
    parameter int ROWS   = 16,
    parameter int PIX_W  = 8,
    parameter int ANG_W  = 8,
    parameter int ELEV_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PIX_W-1:0]         in_pix,
    input  logic [PIX_W-1:0]         thresh,
    input  logic [ANG_W:0]           alpha,
    output logic                     out_valid,
    output logic signed [ELEV_W-1:0] out_elev,
    output logic                     out_row_end
);
    localparam int COL_W    = $clog2(COLS);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int KF       = 16;
    localparam int NUM_W    = ANG_W + 1 + KF;
    localparam int PROD_W   = PIX_W + NUM_W;
    localparam int ANG_FULL = 1 << ANG_W;
    localparam logic signed [ELEV_W:0] E_MAX = (ELEV_W+1)'((1 << (ELEV_W - 1)) - 1);
    localparam logic signed [ELEV_W:0] E_MIN = -E_MAX - (ELEV_W+1)'(1);

    elev_state_e state_q, state_n;

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             accept, scan_acc, map_acc, last_px;

    logic             rd_found;
    logic [COL_W-1:0] rd_first, rd_last;
    logic [PIX_W-1:0] fmin, fmax;
    logic             obj_seen;

    logic             div_start, div_busy, div_done;
    logic [NUM_W-1:0] div_num, div_quot;
    logic [ANG_W:0]   alpha_c, absn_c;
    logic             zero_range;

    logic [ANG_W:0]   a_q;
    logic             neg_q;
    logic [NUM_W-1:0] kmag_q;
    logic [PIX_W-1:0] prev_pix_q;

    // stage A: span decision and brightness distance
    logic             va_q, span_a_q, pos_a_q, rowst_a_q, eol_a_q;
    logic [PIX_W-1:0] diff_a_q;
    // stage B: slope index
    logic             vb_q, span_b_q, pos_b_q, rowst_b_q, eol_b_q;
    logic [ANG_W-1:0] ang_b_q;
    // stage C: output
    logic                     out_valid_q, out_end_q, rowst_c_q;
    logic signed [ELEV_W-1:0] out_elev_q, acc_q;

    logic [PROD_W-1:0]  prod_w;
    int                 q_i, ang_i;
    logic [ANG_W-1:0]   ang_n;
    logic [15:0]        tan_w;
    logic signed [ELEV_W:0]   step_w, sum_w, sat_w;
    logic signed [ELEV_W-1:0] acc_cur;

    shade_span_scan #(
        .COLS (COLS),
        .ROWS (ROWS),
        .PIX_W(PIX_W)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (scan_acc),
        .pix     (in_pix),
        .thresh  (thresh),
        .col     (col_q),
        .row     (row_q),
        .rd_row  (row_q),
        .rd_found(rd_found),
        .rd_first(rd_first),
        .rd_last (rd_last),
        .fmin    (fmin),
        .fmax    (fmax),
        .obj_seen(obj_seen)
    );

    shade_slope_div #(
        .NUM_W(NUM_W),
        .DEN_W(PIX_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (fmax - fmin),
        .busy (div_busy),
        .done (div_done),
        .quot (div_quot)
    );

    shade_tan_rom #(
        .IDX_W(ANG_W)
    ) u_tan (
        .idx  (ang_b_q),
        .tan_q(tan_w)
    );

    // ---------------- control ----------------
    always_comb begin
        accept     = in_valid && in_ready;
        scan_acc   = accept && (state_q == ST_SCAN);
        map_acc    = accept && (state_q == ST_MAP);
        last_px    = (col_q == COL_W'(COLS - 1)) && (row_q == ROW_W'(ROWS - 1));
        zero_range = !obj_seen || (fmax == fmin);
        alpha_c    = (alpha > (ANG_W+1)'(ANG_FULL)) ? (ANG_W+1)'(ANG_FULL) : alpha;
        absn_c     = (alpha_c > (ANG_W+1)'(ANG_FULL / 2))
                   ? ((alpha_c << 1) - (ANG_W+1)'(ANG_FULL))
                   : ((ANG_W+1)'(ANG_FULL) - (alpha_c << 1));
        div_num    = NUM_W'(absn_c) << KF;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SCAN: if (scan_acc && last_px) state_n = ST_LOAD;
            ST_LOAD: state_n = zero_range ? ST_MAP : ST_DIV;
            ST_DIV:  if (div_done) state_n = ST_MAP;
            ST_MAP:  if (map_acc && last_px) state_n = ST_SCAN;
            default: state_n = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_n;
    end

    always_comb begin
        in_ready  = (state_q == ST_SCAN) || (state_q == ST_MAP);
        div_start = (state_q == ST_LOAD) && !zero_range;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            a_q    <= '0;
            neg_q  <= 1'b0;
            kmag_q <= '0;
        end else begin
            if (accept) begin
                if (col_q == COL_W'(COLS - 1)) begin
                    col_q <= '0;
                    row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
            if (state_q == ST_LOAD) begin
                a_q    <= alpha_c;
                neg_q  <= alpha_c > (ANG_W+1)'(ANG_FULL / 2);
                kmag_q <= '0;
            end
            if (state_q == ST_DIV && div_done) begin
                kmag_q <= div_quot;
            end
        end
    end

    // ---------------- second-pass pipeline ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= 1'b0;
            span_a_q   <= 1'b0;
            pos_a_q    <= 1'b0;
            rowst_a_q  <= 1'b0;
            eol_a_q    <= 1'b0;
            diff_a_q   <= '0;
            prev_pix_q <= '0;
        end else begin
            va_q <= map_acc;
            if (map_acc) begin
                span_a_q   <= rd_found && (col_q >= rd_first) && (col_q <= rd_last);
                pos_a_q    <= (col_q == rd_first) || (in_pix >= prev_pix_q);
                rowst_a_q  <= col_q == '0;
                eol_a_q    <= col_q == COL_W'(COLS - 1);
                diff_a_q   <= fmax - in_pix;
                prev_pix_q <= in_pix;
            end
        end
    end

    always_comb begin
        prod_w = PROD_W'(diff_a_q) * PROD_W'(kmag_q);
        q_i    = int'(prod_w[PROD_W-1:KF]);
        ang_i  = neg_q ? (int'(a_q) - q_i) : (int'(a_q) + q_i);
        if (ang_i > ANG_FULL - 1) begin
            ang_n = ANG_W'(ANG_FULL - 1);
        end else if (ang_i < 0) begin
            ang_n = '0;
        end else begin
            ang_n = ANG_W'(ang_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vb_q      <= 1'b0;
            span_b_q  <= 1'b0;
            pos_b_q   <= 1'b0;
            rowst_b_q <= 1'b0;
            eol_b_q   <= 1'b0;
            ang_b_q   <= '0;
        end else begin
            vb_q <= va_q;
            if (va_q) begin
                span_b_q  <= span_a_q;
                pos_b_q   <= pos_a_q;
                rowst_b_q <= rowst_a_q;
                eol_b_q   <= eol_a_q;
                ang_b_q   <= ang_n;
            end
        end
    end

    always_comb begin
        acc_cur = rowst_b_q ? '0 : acc_q;
        step_w  = pos_b_q ? $signed((ELEV_W+1)'(tan_w)) : -$signed((ELEV_W+1)'(tan_w));
        sum_w   = $signed({acc_cur[ELEV_W-1], acc_cur}) + step_w;
        if (sum_w > E_MAX) begin
            sat_w = E_MAX;
        end else if (sum_w < E_MIN) begin
            sat_w = E_MIN;
        end else begin
            sat_w = sum_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_end_q   <= 1'b0;
            rowst_c_q   <= 1'b0;
            out_elev_q  <= '0;
            acc_q       <= '0;
        end else begin
            out_valid_q <= vb_q;
            if (vb_q) begin
                out_end_q  <= eol_b_q;
                rowst_c_q  <= rowst_b_q;
                out_elev_q <= span_b_q ? acc_cur : '0;
                acc_q      <= span_b_q ? sat_w[ELEV_W-1:0] : acc_cur;
            end
        end
    end

    assign out_valid   = out_valid_q;
    assign out_elev    = out_elev_q;
    assign out_row_end = out_end_q;

    p_beat_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_q == $past(map_acc, 3));

    p_rowstart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && rowst_c_q) |-> (out_elev_q == '0));

    p_stall_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !in_ready);

endmodule

// File: tb/shade_row_elev_bench.sv
`timescale 1ns/1ps
module shade_row_elev_bench;
    localparam int COLS = 64;
    localparam int ROWS = 16;
    localparam int EW   = 20;
    localparam int EMAX = (1 << (EW - 1)) - 1;
    localparam int EMIN = -(1 << (EW - 1));

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [7:0]           in_pix = '0;
    logic [7:0]           thresh = '0;
    logic [8:0]           alpha = '0;
    logic                 out_valid;
    logic signed [EW-1:0] out_elev;
    logic                 out_row_end;

    int    frame [ROWS][COLS];
    int    exp_elev[$];
    int    exp_end[$];
    string exp_tag[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    shade_row_elev u_shade_row_elev (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .thresh(thresh), .alpha(alpha), .out_valid(out_valid),
        .out_elev(out_elev), .out_row_end(out_row_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int tan_ref(input int k);
        real v;
        v = $tan(real'(k) * 3.141592653589793 / 512.0) * 256.0 + 0.5;
        if (v > 65535.0) return 65535;
        return $rtoi(v);
    endfunction

    // expected output stream from the requirements
    task automatic build_expected(input int thr, input int alp, input string tag);
        int first [ROWS];
        int last [ROWS];
        int fmin, fmax, a, absn, d;
        bit neg, obj;
        longint k;
        fmin = 255; fmax = 0; obj = 0;
        for (int r = 0; r < ROWS; r++) begin
            first[r] = -1; last[r] = -1;
            for (int c = 0; c < COLS; c++) begin
                if (frame[r][c] > thr) begin
                    if (first[r] < 0) first[r] = c;
                    last[r] = c;
                end
            end
            if (first[r] >= 0) begin
                obj = 1;
                for (int c = first[r]; c <= last[r]; c++) begin
                    if (frame[r][c] < fmin) fmin = frame[r][c];
                    if (frame[r][c] > fmax) fmax = frame[r][c];
                end
            end
        end
        a    = (alp > 256) ? 256 : alp;
        neg  = a > 128;
        absn = neg ? (2 * a - 256) : (256 - 2 * a);
        d    = fmax - fmin;
        k    = (obj && d > 0) ? ((longint'(absn) * 65536) / d) : 0;
        for (int r = 0; r < ROWS; r++) begin
            int acc;
            bit prev_neg;
            acc = 0; prev_neg = 0;
            for (int c = 0; c < COLS; c++) begin
                string t;
                int outv;
                if (first[r] >= 0 && c >= first[r] && c <= last[r]) begin
                    int q, ang, st;
                    bit pos;
                    q   = int'((longint'(fmax - frame[r][c]) * k) >>> 16);
                    ang = neg ? (a - q) : (a + q);
                    if (ang > 255) ang = 255;
                    if (ang < 0) ang = 0;
                    pos = (c == first[r]) || (frame[r][c] >= frame[r][c-1]);
                    st  = pos ? tan_ref(ang) : -tan_ref(ang);
                    outv = acc;
                    if (c == first[r]) t = "R7";
                    else if (outv == EMAX || outv == EMIN) t = "R8";
                    else if (prev_neg) t = "R6";
                    else if (c == first[r] + 1) t = "R5";
                    else t = tag;
                    acc = acc + st;
                    if (acc > EMAX) acc = EMAX;
                    if (acc < EMIN) acc = EMIN;
                    prev_neg = !pos;
                end else begin
                    outv = 0;
                    t = "R1";
                end
                exp_elev.push_back(outv);
                exp_end.push_back(c == COLS - 1);
                exp_tag.push_back(t);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (exp_elev.size() == 0) begin
                chk(1'b0, "R9 extra beat", 1, 0);
            end else begin
                int e, en;
                string t;
                e = exp_elev.pop_front();
                en = exp_end.pop_front();
                t = exp_tag.pop_front();
                chk(int'(out_elev) == e, t, int'(out_elev), e);
                chk(int'(out_row_end) == en, "R9 row end", int'(out_row_end), en);
            end
        end
    end

    task automatic send_pass();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                while (!in_ready) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                if (($urandom % 8) == 0) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                    while (!in_ready) @(negedge clk);
                end
                in_valid = 1'b1;
                in_pix = 8'(frame[r][c]);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input int thr, input int alp, input string tag);
        thresh = 8'(thr);
        alpha  = 9'(alp);
        build_expected(thr, alp, tag);
        send_pass();
        // in_valid dropped one negedge after the last beat was taken
        chk(in_ready == 1'b0, "R10 stall after scan", int'(in_ready), 0);
        chk(exp_elev.size() == ROWS * COLS, "R9 no beats in scan", exp_elev.size(), ROWS * COLS);
        send_pass();
        repeat (8) @(negedge clk);
        chk(exp_elev.size() == 0, "R9 beat count", exp_elev.size(), 0);
        chk(in_ready == 1'b1, "R10 ready for next frame", int'(in_ready), 1);
    endtask

    task automatic fill_random(input int thr);
        for (int r = 0; r < ROWS; r++) begin
            int s, e;
            s = $urandom % COLS;
            e = s + ($urandom % (COLS - s));
            for (int c = 0; c < COLS; c++) begin
                if (c >= s && c <= e && ($urandom % 6) != 0) frame[r][c] = thr + 1 + ($urandom % (255 - thr));
                else if (c >= s && c <= e) frame[r][c] = $urandom % 256;
                else frame[r][c] = $urandom % (thr + 1);
            end
            if (($urandom % 5) == 0) begin
                for (int c = 0; c < COLS; c++) frame[r][c] = $urandom % (thr + 1);
            end
        end
    endtask

    task automatic fill_const(input int bg, input int fg, input int s, input int e);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                frame[r][c] = (c >= s && c <= e) ? fg : bg;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7531));
        repeat (5) @(negedge clk);
        chk(in_ready == 1'b1, "R10 reset ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9 reset idle", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);

        // R3: random spans, light below 45 degrees
        fill_random(30);
        run_frame(30, 60, "R3");
        // R3: light above 45 degrees, reversed regression
        fill_random(20);
        run_frame(20, 200, "R3");
        // R4: single brightness level, alpha clipped from 300
        fill_const(10, 100, 5, 50);
        run_frame(50, 300, "R4");
        // R2: in-span dip below threshold is the frame minimum
        fill_random(40);
        for (int c = 0; c < COLS; c++) frame[3][c] = 0;
        frame[3][10] = 120; frame[3][11] = 3; frame[3][12] = 250; frame[3][13] = 90;
        for (int c = 0; c < COLS; c++) if (frame[5][c] < 4) frame[5][c] = 4;
        for (int r = 0; r < ROWS; r++) if (r != 3) for (int c = 0; c < COLS; c++)
            if (frame[r][c] < 4) frame[r][c] = 4;
        run_frame(40, 90, "R2");
        // R8: flat dark row under grazing light saturates the sum
        fill_const(0, 10, 0, COLS - 1);
        for (int c = 0; c < COLS; c++) frame[7][c] = 200;
        run_frame(5, 0, "R8");
        // R1: nothing above the threshold
        fill_const(0, 60, 0, COLS - 1);
        run_frame(60, 100, "R1");
        // random light angles
        for (int i = 0; i < 3; i++) begin
            int alp;
            alp = $urandom % 257;
            fill_random(25);
            run_frame(25, alp, "R3");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule